// File: doc/BRIEF.md
# Special-Purpose Register Write Unit with Memory-Latency Alignment

This block holds the seven 16-bit special-purpose registers of a small processor core: timer load, I/O output, stack push, queue push, I/O input, interrupt data and program counter. A register can be written from two places. One is the ALU/register data bus, which is valid in the same cycle as the write controls. The other is the data-memory read port, whose data arrives one cycle after the controls.

The block registers the memory-write controls for one cycle: the memory flag, the 3-bit target select and the 2-bit load field. The memory data then meets its controls in the cycle it arrives, so both kinds of write fit in one instruction slot.

Four of the registers drive a chip-select line to their sub-unit. On a write, that line is derived from the load field, so the value either goes to the sub-unit or stays as general-purpose storage. When a register is not written, it keeps its value and its chip-select line follows a direct per-unit input, registered. The I/O-input register drives its port all the time and has no enable.

Top module: `spr_write_unit`

## Requirements
- R1: The target select `sel` is encoded as 001 timer, 010 I/O output, 011 stack, 100 queue, 101 I/O input, 110 interrupt data and 111 program counter. The value 000 writes nothing, from either source.
- R2: When `bus_wr` is high and `sel` names a register at a rising edge, that register takes `bus_data` at that edge.
- R3: When `mem_wr` is high at edge N, the register named by `sel` at edge N takes `mem_data` as sampled at edge N+1. Its chip select is derived from `ld_cs` as sampled at edge N, not from the value at edge N+1.
- R4: On a write, `tmr_cs` and `iow_cs` become 1 when the load field is non-zero. `stk_push` and `que_push` become 1 only for load field 01 or 11, so 10 gives 0. A write overrides the direct chip-select input.
- R5: A register that is not written at an edge keeps its value.
- R6: At an edge where a chip-select register is not written, its chip-select output takes the value of its direct input (`*_cs_in`) at that edge.
- R7: The I/O-input, interrupt-data and program-counter registers drive no chip-select line. Writing them leaves all four chip-select outputs at their idle values. `ior_q` always shows the stored I/O-input value.
- R8: If a delayed memory write and a bus write target the same register at the same edge, the memory data and the memory load field win.
- R9: A synchronous active-high `rst` clears all seven registers and all four chip-select outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 3 | Target register select |
| ld_cs | input | 2 | Load / chip-select field |
| bus_wr | input | 1 | Write from the data bus this cycle |
| mem_wr | input | 1 | Write from memory (data follows next cycle) |
| bus_data | input | 16 | Data bus value |
| mem_data | input | 16 | Memory read data |
| tmr_cs_in | input | 1 | Direct timer chip select |
| iow_cs_in | input | 1 | Direct I/O output chip select |
| stk_cs_in | input | 1 | Direct stack push |
| que_cs_in | input | 1 | Direct queue push |
| tmr_q | output | 16 | Timer register |
| iow_q | output | 16 | I/O output register |
| stk_q | output | 16 | Stack push register |
| que_q | output | 16 | Queue push register |
| ior_q | output | 16 | I/O input register (continuous) |
| irq_q | output | 16 | Interrupt data register |
| pc_q | output | 16 | Program counter register |
| tmr_cs | output | 1 | Timer chip select |
| iow_cs | output | 1 | I/O output chip select |
| stk_push | output | 1 | Stack push |
| que_push | output | 1 | Queue push |

## Verification
A table interleaves bus writes and memory writes across every select code, including 000 from both sources. Each write carries a distinct data word, so a write that lands in the wrong register, or in the wrong cycle of the memory path, shows up as a mismatch. The load field takes all four codes on the chip-select registers, which separates the non-zero rule used by the timer and I/O output from the bit-0 rule used by the stack and queue. Directed cases set the direct chip-select inputs high during idle and during a write with load 00, which tells the idle path apart from the write path. A collision case changes the load field between the two memory cycles, showing that memory data and the delayed load field win over a same-cycle bus write.

// File: rtl/spr_pkg.sv
package spr_pkg;

    localparam int SPR_W   = 16;
    localparam int SEL_W   = 3;
    localparam int LD_W    = 2;
    localparam int NUM_SPR = 7;

    typedef enum logic [SEL_W-1:0] {
        SPR_NONE = 3'd0,
        SPR_TMR  = 3'd1,
        SPR_IOW  = 3'd2,
        SPR_STK  = 3'd3,
        SPR_QUE  = 3'd4,
        SPR_IOR  = 3'd5,
        SPR_IRQ  = 3'd6,
        SPR_PC   = 3'd7
    } spr_id_e;

    typedef enum logic [1:0] {
        CS_NONE  = 2'd0,
        CS_LEVEL = 2'd1,
        CS_PUSH  = 2'd2
    } cs_kind_e;

    typedef struct packed {
        logic             vld;
        logic [SEL_W-1:0] sel;
        logic [LD_W-1:0]  ld;
    } align_t;

    function automatic cs_kind_e kind_of(input int idx);
        case (idx)
            1, 2:    kind_of = CS_LEVEL;
            3, 4:    kind_of = CS_PUSH;
            default: kind_of = CS_NONE;
        endcase
    endfunction

    function automatic logic cs_of(input cs_kind_e kind, input logic [LD_W-1:0] ld);
        case (kind)
            CS_LEVEL: cs_of = |ld;
            CS_PUSH:  cs_of = ld[0];
            default:  cs_of = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/spr_align.sv
module spr_align
    import spr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mem_wr,
    input  logic [SEL_W-1:0] sel,
    input  logic [LD_W-1:0]  ld,
    output align_t           dly
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dly <= '0;
        end else begin
            dly.vld <= mem_wr;
            dly.sel <= sel;
            dly.ld  <= ld;
        end
    end

endmodule

// File: rtl/spr_slot.sv
module spr_slot
    import spr_pkg::*;
#(
    parameter int       W    = SPR_W,
    parameter cs_kind_e KIND = CS_NONE
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mem_hit,
    input  logic            bus_hit,
    input  logic [W-1:0]    mem_d,
    input  logic [W-1:0]    bus_d,
    input  logic [LD_W-1:0] mem_ld,
    input  logic [LD_W-1:0] bus_ld,
    input  logic            dir_cs,
    output logic [W-1:0]    q,
    output logic            cs
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q  <= '0;
            cs <= 1'b0;
        end else if (mem_hit) begin
            q  <= mem_d;
            cs <= cs_of(KIND, mem_ld);
        end else if (bus_hit) begin
            q  <= bus_d;
            cs <= cs_of(KIND, bus_ld);
        end else begin
            cs <= dir_cs;
        end
    end

    // R3 R8
    mem_capture_chk: assert property (@(posedge clk) disable iff (rst)
        mem_hit |=> q == $past(mem_d));

    // R2
    bus_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_hit && !mem_hit) |=> q == $past(bus_d));

    // R5
    hold_value_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_hit && !mem_hit) |=> $stable(q));

    // R6
    idle_cs_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_hit && !mem_hit) |=> cs == $past(dir_cs));

endmodule

// File: rtl/spr_write_unit.sv
module spr_write_unit
    import spr_pkg::*;
#(
    parameter int DATA_W = SPR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  sel,
    input  logic [LD_W-1:0]   ld_cs,
    input  logic              bus_wr,
    input  logic              mem_wr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [DATA_W-1:0] mem_data,
    input  logic              tmr_cs_in,
    input  logic              iow_cs_in,
    input  logic              stk_cs_in,
    input  logic              que_cs_in,
    output logic [DATA_W-1:0] tmr_q,
    output logic [DATA_W-1:0] iow_q,
    output logic [DATA_W-1:0] stk_q,
    output logic [DATA_W-1:0] que_q,
    output logic [DATA_W-1:0] ior_q,
    output logic [DATA_W-1:0] irq_q,
    output logic [DATA_W-1:0] pc_q,
    output logic              tmr_cs,
    output logic              iow_cs,
    output logic              stk_push,
    output logic              que_push
);

    localparam int FLAT_W = NUM_SPR * DATA_W;

    align_t              dly;
    logic [NUM_SPR:1]    mem_hit;
    logic [NUM_SPR:1]    bus_hit;
    logic [NUM_SPR:1]    dir_vec;
    logic [NUM_SPR:1]    cs_vec;
    logic [DATA_W-1:0]   q_arr [1:NUM_SPR];
    logic [FLAT_W-1:0]   q_flat;

    spr_align u_align (
        .clk    (clk),
        .rst    (rst),
        .mem_wr (mem_wr),
        .sel    (sel),
        .ld     (ld_cs),
        .dly    (dly)
    );

    assign dir_vec = {3'b000, que_cs_in, stk_cs_in, iow_cs_in, tmr_cs_in};

    for (genvar k = 1; k <= NUM_SPR; k++) begin : g_slot
        localparam logic [SEL_W-1:0] KID = SEL_W'(k);

        assign mem_hit[k] = dly.vld && (dly.sel == KID);
        assign bus_hit[k] = bus_wr && (sel == KID);

        spr_slot #(
            .W    (DATA_W),
            .KIND (kind_of(k))
        ) u_slot (
            .clk     (clk),
            .rst     (rst),
            .mem_hit (mem_hit[k]),
            .bus_hit (bus_hit[k]),
            .mem_d   (mem_data),
            .bus_d   (bus_data),
            .mem_ld  (dly.ld),
            .bus_ld  (ld_cs),
            .dir_cs  (dir_vec[k]),
            .q       (q_arr[k]),
            .cs      (cs_vec[k])
        );

        assign q_flat[(k-1)*DATA_W +: DATA_W] = q_arr[k];
    end

    assign tmr_q    = q_arr[SPR_TMR];
    assign iow_q    = q_arr[SPR_IOW];
    assign stk_q    = q_arr[SPR_STK];
    assign que_q    = q_arr[SPR_QUE];
    assign ior_q    = q_arr[SPR_IOR];
    assign irq_q    = q_arr[SPR_IRQ];
    assign pc_q     = q_arr[SPR_PC];
    assign tmr_cs   = cs_vec[SPR_TMR];
    assign iow_cs   = cs_vec[SPR_IOW];
    assign stk_push = cs_vec[SPR_STK];
    assign que_push = cs_vec[SPR_QUE];

    // R1
    null_select_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SPR_NONE && !dly.vld) |=> $stable(q_flat));

    // R7
    no_cs_slots_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(cs_vec[NUM_SPR:SPR_IOR]) == 0);

endmodule

// File: tb/spr_write_unit_test.sv
`timescale 1ns/1ps
module spr_write_unit_test;
    import spr_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  sel = '0;
    logic [1:0]  ld_cs = '0;
    logic        bus_wr = 1'b0, mem_wr = 1'b0;
    logic [15:0] bus_data = '0, mem_data = '0;
    logic        tmr_cs_in = 1'b0, iow_cs_in = 1'b0, stk_cs_in = 1'b0, que_cs_in = 1'b0;
    logic [15:0] tmr_q, iow_q, stk_q, que_q, ior_q, irq_q, pc_q;
    logic        tmr_cs, iow_cs, stk_push, que_push;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [15:0] exp_q [1:7];
    logic        exp_cs [1:4];

    always #2.5 clk = ~clk;

    spr_write_unit uut (
        .clk(clk), .rst(rst), .sel(sel), .ld_cs(ld_cs),
        .bus_wr(bus_wr), .mem_wr(mem_wr), .bus_data(bus_data), .mem_data(mem_data),
        .tmr_cs_in(tmr_cs_in), .iow_cs_in(iow_cs_in), .stk_cs_in(stk_cs_in), .que_cs_in(que_cs_in),
        .tmr_q(tmr_q), .iow_q(iow_q), .stk_q(stk_q), .que_q(que_q),
        .ior_q(ior_q), .irq_q(irq_q), .pc_q(pc_q),
        .tmr_cs(tmr_cs), .iow_cs(iow_cs), .stk_push(stk_push), .que_push(que_push)
    );

    // vector: [21] memory source, [20:18] sel, [17:16] load field, [15:0] data
    localparam logic [21:0] VEC [12] = '{
        {1'b0, 3'd1, 2'b01, 16'h1111},
        {1'b0, 3'd2, 2'b00, 16'h2222},
        {1'b1, 3'd3, 2'b10, 16'h3333},
        {1'b1, 3'd4, 2'b11, 16'h4444},
        {1'b0, 3'd3, 2'b01, 16'h5555},
        {1'b1, 3'd1, 2'b10, 16'h6666},
        {1'b0, 3'd5, 2'b11, 16'h7777},
        {1'b1, 3'd6, 2'b01, 16'h8888},
        {1'b0, 3'd7, 2'b00, 16'h9999},
        {1'b1, 3'd2, 2'b11, 16'hAAAA},
        {1'b0, 3'd0, 2'b11, 16'hBBBB},
        {1'b1, 3'd0, 2'b01, 16'hCCCC}
    };

    function automatic logic [15:0] get_q(input int k);
        case (k)
            1: get_q = tmr_q;
            2: get_q = iow_q;
            3: get_q = stk_q;
            4: get_q = que_q;
            5: get_q = ior_q;
            6: get_q = irq_q;
            default: get_q = pc_q;
        endcase
    endfunction

    function automatic logic get_cs(input int k);
        case (k)
            1: get_cs = tmr_cs;
            2: get_cs = iow_cs;
            3: get_cs = stk_push;
            default: get_cs = que_push;
        endcase
    endfunction

    // bench-side rule: timer and I/O output select on any non-zero load; stack and queue on 01 or 11
    function automatic logic want_cs(input int k, input logic [1:0] ld);
        if (k <= 2) want_cs = (ld != 2'b00);
        else        want_cs = (ld == 2'b01) || (ld == 2'b11);
    endfunction

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        for (int k = 1; k <= 7; k++)
            chk(req, $sformatf("reg%0d", k), get_q(k), exp_q[k]);
        for (int k = 1; k <= 4; k++)
            chk(req, $sformatf("cs%0d", k), 16'(get_cs(k)), 16'(exp_cs[k]));
    endtask

    task automatic idle_inputs();
        bus_wr = 1'b0; mem_wr = 1'b0; sel = '0; ld_cs = '0;
    endtask

    task automatic bus_write(input logic [2:0] s, input logic [1:0] ld, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; sel = s; ld_cs = ld; bus_data = d;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic mem_write(input logic [2:0] s, input logic [1:0] ld, input logic [15:0] d);
        @(negedge clk);
        mem_wr = 1'b1; sel = s; ld_cs = ld;
        @(negedge clk);
        idle_inputs();
        mem_data = d;
        @(negedge clk);
        mem_data = 16'h0;
    endtask

    task automatic clear_model();
        for (int k = 1; k <= 7; k++) exp_q[k] = 16'h0;
        for (int k = 1; k <= 4; k++) exp_cs[k] = 1'b0;
    endtask

    initial begin
        clear_model();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk_all("R9");

        // table: R1 R2 R3 R4 R5 R7
        for (int i = 0; i < 12; i++) begin
            logic        is_mem;
            logic [2:0]  s;
            logic [1:0]  ld;
            logic [15:0] d;
            {is_mem, s, ld, d} = VEC[i];
            if (is_mem) mem_write(s, ld, d);
            else        bus_write(s, ld, d);
            if (s != 3'd0) exp_q[s] = d;
            for (int k = 1; k <= 4; k++)
                exp_cs[k] = (k == int'(s)) ? want_cs(k, ld) : 1'b0;
            chk_all(is_mem ? "R3" : "R2");
        end

        // R6: idle chip selects follow the direct inputs, registers hold (R5)
        @(negedge clk);
        tmr_cs_in = 1'b1; iow_cs_in = 1'b1; stk_cs_in = 1'b1; que_cs_in = 1'b1;
        @(negedge clk);
        for (int k = 1; k <= 4; k++) exp_cs[k] = 1'b1;
        chk_all("R6");

        // R4: write with load 00 overrides a high direct input
        bus_write(3'd1, 2'b00, 16'h0F0F);
        exp_q[1] = 16'h0F0F; exp_cs[1] = 1'b0;
        chk_all("R4");
        tmr_cs_in = 1'b0; iow_cs_in = 1'b0; stk_cs_in = 1'b0; que_cs_in = 1'b0;
        @(negedge clk);
        for (int k = 1; k <= 4; k++) exp_cs[k] = 1'b0;
        chk_all("R6");

        // R8: delayed memory write and bus write collide on I/O output register
        @(negedge clk);
        mem_wr = 1'b1; sel = 3'd2; ld_cs = 2'b01;
        @(negedge clk);
        mem_wr = 1'b0; bus_wr = 1'b1; sel = 3'd2; ld_cs = 2'b00;
        bus_data = 16'h1234; mem_data = 16'hBEEF;
        @(negedge clk);
        idle_inputs(); mem_data = 16'h0;
        exp_q[2] = 16'hBEEF; exp_cs[2] = 1'b1;
        chk_all("R8");

        // R3: memory chip select uses the delayed load field (10 then 01 on the stack)
        @(negedge clk);
        mem_wr = 1'b1; sel = 3'd3; ld_cs = 2'b10;
        @(negedge clk);
        mem_wr = 1'b0; sel = 3'd0; ld_cs = 2'b01; mem_data = 16'h5A5A;
        @(negedge clk);
        idle_inputs(); mem_data = 16'h0;
        exp_q[3] = 16'h5A5A;
        for (int k = 1; k <= 4; k++) exp_cs[k] = 1'b0;
        chk_all("R3");

        // R7: I/O input value visible continuously, across idle cycles
        repeat (3) @(negedge clk);
        chk("R7", "ior hold", ior_q, 16'h7777);

        // R9: reset in mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        tmr_cs_in = 1'b1;
        @(negedge clk);
        clear_model();
        chk_all("R9");
        rst = 1'b0; tmr_cs_in = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule